// File: doc/BRIEF.md
# Reset cause status register

This block keeps a record of which reset source, or sources, fired most recently, and shows that record as an 8-bit read-only status value on a small memory-mapped bus. Each reset source supplies a one-cycle request pulse: power-on, the external reset pin, watchdog timeout, illegal opcode, illegal address, forced mode reset and low-voltage detect. A power-on pulse starts a fresh record. Every other source only adds its own flag. Software reads the value once after reset to find the cause, and that read also empties the register.

The flags are registered. The read data output shows the stored flags at all times. A bus read is a cycle with the select line high and the direction line high. It returns the value held before the clear. The register is empty from the next clock edge, except for any request that arrives in that same cycle. A bus cycle with the direction line low is a write, and it changes nothing. The housekeeping reset is synchronous and active high, and it empties the register.

Top module: `rcs_reset_cause`

## Requirements
- R1: While `rst` is high at a clock edge, the register becomes 0x00 after that edge.
- R2: A power-on pulse (`pwron_req`) causes the next value to contain bit 7 plus only the flags of other sources pulsing in that same cycle. All previously held flags are cleared.
- R3: When there is no power-on pulse and no read, a pulse from any other source sets its own flag on the next edge, and every other flag keeps its value.
- R4: Flags from different sources accumulate, so several can be set at once.
- R5: The bit positions are fixed: 7 power-on, 6 external pin, 5 watchdog, 4 illegal opcode, 3 illegal address, 2 forced mode, 1 low voltage.
- R6: Bit 0 always reads 0.
- R7: A read (`bus_sel`=1, `bus_rnw`=1) sees the flags held before the clear. After the next edge the register is 0x00 unless a request also arrives in that cycle.
- R8: A write cycle (`bus_sel`=1, `bus_rnw`=0) leaves the register unchanged.
- R9: A non-power-on request in the same cycle as a read is kept after the clear.
- R10: A power-on pulse together with another source in the same cycle leaves both of their flags set.
- R11: `bus_rnw`=1 with `bus_sel`=0 does not clear the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high housekeeping reset |
| pwron_req | input | 1 | Power-on reset request pulse |
| extpin_req | input | 1 | External reset pin request pulse |
| wdog_req | input | 1 | Watchdog timeout request pulse |
| badop_req | input | 1 | Illegal opcode request pulse |
| badaddr_req | input | 1 | Illegal address request pulse |
| forced_req | input | 1 | Forced mode reset request pulse |
| lowv_req | input | 1 | Low-voltage detect request pulse |
| bus_sel | input | 1 | Register select |
| bus_rnw | input | 1 | Direction: 1 read, 0 write |
| rd_data | output | 8 | Status value (bit 0 always 0) |

## Verification
On every cycle, the assertions check the next-state rules. These are: the wipe caused by a power-on pulse, accumulation when there is no read, the clear caused by a read with same-cycle requests kept, writes being ignored, and the zero pad bit. Only the bench scenarios can show the fixed bit position of each source. The same goes for the value returned during the read cycle itself, and for longer sequences such as accumulating flags, clearing them and rebuilding them around a power-on pulse.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

    parameter int unsigned NUM_SRC   = 7;
    parameter int unsigned FIELD_LSB = 1;
    localparam int unsigned DATA_W   = NUM_SRC + FIELD_LSB;

    // Source index inside the flag vector; register bit = index + FIELD_LSB.
    typedef enum int unsigned {
        SRC_LOWV    = 0,
        SRC_FORCED  = 1,
        SRC_BADADDR = 2,
        SRC_BADOP   = 3,
        SRC_WDOG    = 4,
        SRC_EXTPIN  = 5,
        SRC_PWRON   = 6
    } src_e;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    typedef struct packed {
        logic sel;
        logic rnw;
    } bus_cyc_t;

    function automatic logic [DATA_W-1:0] pack_flags(src_vec_t f);
        logic [DATA_W-1:0] v;
        v = '0;
        v[DATA_W-1:FIELD_LSB] = f;
        return v;
    endfunction

endpackage

// File: rtl/rcs_bus_decode.sv
module rcs_bus_decode
    import rcs_pkg::*;
(
    input  bus_cyc_t cyc,
    output logic     rd_clr
);
    always_comb begin
        rd_clr = cyc.sel && cyc.rnw;
    end
endmodule

// File: rtl/rcs_flag_next.sv
module rcs_flag_next #(
    parameter int unsigned N       = 7,
    parameter int unsigned PWR_IDX = 6
) (
    input  logic [N-1:0] req,
    input  logic [N-1:0] cur,
    input  logic         rd_clr,
    output logic [N-1:0] nxt
);
    logic keep;

    always_comb begin
        keep = !req[PWR_IDX] && !rd_clr;
    end

    for (genvar g = 0; g < N; g++) begin : g_bit
        assign nxt[g] = req[g] | (cur[g] & keep);
    end
endmodule

// File: rtl/rcs_flag_store.sv
module rcs_flag_store #(
    parameter int unsigned N = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] nxt,
    output logic [N-1:0] cur
);
    for (genvar g = 0; g < N; g++) begin : g_ff
        always_ff @(posedge clk) begin
            if (rst) cur[g] <= 1'b0;
            else     cur[g] <= nxt[g];
        end
    end
endmodule

// File: rtl/rcs_reset_cause.sv
module rcs_reset_cause
    import rcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pwron_req,
    input  logic              extpin_req,
    input  logic              wdog_req,
    input  logic              badop_req,
    input  logic              badaddr_req,
    input  logic              forced_req,
    input  logic              lowv_req,
    input  logic              bus_sel,
    input  logic              bus_rnw,
    output logic [DATA_W-1:0] rd_data
);
    src_vec_t req;
    src_vec_t cur;
    src_vec_t nxt;
    bus_cyc_t cyc;
    logic     rd_clr;

    always_comb begin
        req = '0;
        req[SRC_PWRON]   = pwron_req;
        req[SRC_EXTPIN]  = extpin_req;
        req[SRC_WDOG]    = wdog_req;
        req[SRC_BADOP]   = badop_req;
        req[SRC_BADADDR] = badaddr_req;
        req[SRC_FORCED]  = forced_req;
        req[SRC_LOWV]    = lowv_req;
        cyc.sel = bus_sel;
        cyc.rnw = bus_rnw;
    end

    rcs_bus_decode u_dec (
        .cyc    (cyc),
        .rd_clr (rd_clr)
    );

    rcs_flag_next #(
        .N       (NUM_SRC),
        .PWR_IDX (int'(SRC_PWRON))
    ) u_next (
        .req    (req),
        .cur    (cur),
        .rd_clr (rd_clr),
        .nxt    (nxt)
    );

    rcs_flag_store #(.N(NUM_SRC)) u_store (
        .clk (clk),
        .rst (rst),
        .nxt (nxt),
        .cur (cur)
    );

    always_comb begin
        rd_data = pack_flags(cur);
    end
endmodule

// File: rtl/rcs_reset_cause_chk.sv
module rcs_reset_cause_chk
    import rcs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              pwron_req,
    input logic              extpin_req,
    input logic              wdog_req,
    input logic              badop_req,
    input logic              badaddr_req,
    input logic              forced_req,
    input logic              lowv_req,
    input logic              bus_sel,
    input logic              bus_rnw,
    input logic [DATA_W-1:0] rd_data
);
    logic [NUM_SRC-1:0] rq;
    assign rq = {pwron_req, extpin_req, wdog_req, badop_req,
                 badaddr_req, forced_req, lowv_req};

    assert_rst_empty_R1: assert property (@(posedge clk)
        rst |=> rd_data == '0);

    assert_pwron_wipe_R2: assert property (@(posedge clk) disable iff (rst)
        pwron_req |=> rd_data[DATA_W-1:FIELD_LSB] == $past(rq));

    assert_accumulate_R3: assert property (@(posedge clk) disable iff (rst)
        (!pwron_req && !(bus_sel && bus_rnw)) |=>
        rd_data[DATA_W-1:FIELD_LSB] ==
            ($past(rd_data[DATA_W-1:FIELD_LSB]) | $past(rq)));

    assert_pad_zero_R6: assert property (@(posedge clk) disable iff (rst)
        rd_data[0] == 1'b0);

    assert_read_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_rnw && !pwron_req) |=>
        rd_data[DATA_W-1:FIELD_LSB] == $past(rq));

    assert_write_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_rnw && rq == '0) |=> $stable(rd_data));
endmodule

bind rcs_reset_cause rcs_reset_cause_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .pwron_req   (pwron_req),
    .extpin_req  (extpin_req),
    .wdog_req    (wdog_req),
    .badop_req   (badop_req),
    .badaddr_req (badaddr_req),
    .forced_req  (forced_req),
    .lowv_req    (lowv_req),
    .bus_sel     (bus_sel),
    .bus_rnw     (bus_rnw),
    .rd_data     (rd_data)
);

// File: tb/test_rcs_reset_cause.sv
module test_rcs_reset_cause;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] ev  = '0;   // {pwron, extpin, wdog, badop, badaddr, forced, lowv}
    logic       sel = 1'b0;
    logic       rnw = 1'b0;
    logic [7:0] rd_data;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    rcs_reset_cause i_rcs_reset_cause (
        .clk         (clk),
        .rst         (rst),
        .pwron_req   (ev[6]),
        .extpin_req  (ev[5]),
        .wdog_req    (ev[4]),
        .badop_req   (ev[3]),
        .badaddr_req (ev[2]),
        .forced_req  (ev[1]),
        .lowv_req    (ev[0]),
        .bus_sel     (sel),
        .bus_rnw     (rnw),
        .rd_data     (rd_data)
    );

    // {events[6:0], sel, rnw, expected value after the edge}
    localparam int NV = 16;
    localparam logic [16:0] VEC [NV] = '{
        {7'b0000001, 1'b0, 1'b0, 8'h02},  // R3 low voltage alone
        {7'b0100000, 1'b0, 1'b0, 8'h42},  // R4 pin adds to low voltage
        {7'b0000000, 1'b1, 1'b0, 8'h42},  // R8 write ignored
        {7'b0000000, 1'b0, 1'b1, 8'h42},  // R11 rnw without select
        {7'b1000000, 1'b0, 1'b0, 8'h80},  // R2 power-on wipes
        {7'b0010000, 1'b0, 1'b0, 8'hA0},  // R3 watchdog added
        {7'b0000000, 1'b1, 1'b1, 8'h00},  // R7 read clears
        {7'b0001000, 1'b1, 1'b1, 8'h10},  // R9 request kept over read
        {7'b0000000, 1'b1, 1'b1, 8'h00},  // R7 read clears
        {7'b1000001, 1'b0, 1'b0, 8'h82},  // R10 power-on with low voltage
        {7'b0000100, 1'b0, 1'b0, 8'h8A},  // R4 illegal address added
        {7'b0000010, 1'b0, 1'b0, 8'h8E},  // R4 forced mode added
        {7'b1000010, 1'b1, 1'b1, 8'h84},  // R10 power-on with forced during read
        {7'b0111111, 1'b0, 1'b0, 8'hFE},  // R4 all sources set
        {7'b0000000, 1'b1, 1'b1, 8'h00},  // R7 read clears
        {7'b0000000, 1'b0, 1'b0, 8'h00}   // R6 idle, bit 0 stays 0
    };
    localparam int VREQ [NV] = '{3, 4, 8, 11, 2, 3, 7, 9, 7, 10, 4, 4, 10, 4, 7, 6};

    task automatic check(input int req, input logic [7:0] exp);
        checks++;
        if (rd_data !== exp) begin
            fails++;
            $display("FAIL R%0d: rd_data=%02h expected=%02h", req, rd_data, exp);
        end
    endtask

    // drive at a falling edge; the result is sampled at the following falling edge
    task automatic step(input logic [6:0] e, input logic s, input logic r);
        ev = e; sel = s; rnw = r;
        @(negedge clk);
        ev = '0; sel = 1'b0; rnw = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not end, got %0d checks expected completion", checks);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        check(1, 8'h00);                     // R1 reset state
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][16:10], VEC[i][9], VEC[i][8]);
            check(VREQ[i], VEC[i][7:0]);
            if (rd_data[0] !== 1'b0) check(6, 8'h00);  // R6
        end

        // R5: each source alone lands on its fixed bit
        for (int i = 0; i < 7; i++) begin
            step(7'd1 << i, 1'b0, 1'b0);
            check(5, 8'(1 << (i + 1)));
            step(7'b0, 1'b1, 1'b1);
            check(5, 8'h00);
        end

        // R7: the read cycle itself still shows the pre-clear flags
        step(7'b0011000, 1'b0, 1'b0);
        sel = 1'b1; rnw = 1'b1;
        #1 check(7, 8'h30);
        @(negedge clk);
        sel = 1'b0; rnw = 1'b0;
        check(7, 8'h00);

        // R8: a write over several set flags leaves them untouched
        step(7'b0100001, 1'b0, 1'b0);
        step(7'b0, 1'b1, 1'b0);
        step(7'b0, 1'b1, 1'b0);
        check(8, 8'h42);

        // R1: reset in the middle of operation empties the register
        rst = 1'b1;
        @(negedge clk);
        check(1, 8'h00);
        rst = 1'b0;
        step(7'b0000001, 1'b0, 1'b0);
        check(3, 8'h02);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule